// File: doc/BRIEF.md
# SD Host Write Data-Line Engine

This block drives the data lines of an SD card bus during single-block and multiple-block writes. After the command path reports that the card has answered the write command, the engine keeps the lines released for a fixed number of clock cycles. It then sends each block as a start bit, the payload and a per-lane CRC16, followed by an end bit. One bit per lane goes out on each clock.

After the end bit the engine releases the bus for two turnaround cycles and samples the card's three-bit status token on lane 0. It reports whether the block was accepted, rejected for a CRC error, or lost to a card programming failure. While the card holds lane 0 low to show that it has no free receive buffer, the engine waits, and it does not start the next block until the line goes high again. A stop strobe from the command path ends the transfer cleanly.

Payload bytes arrive on a valid/ready stream. Back-pressure rules:
- A byte moves on any cycle where both `s_valid` and `s_ready` are high.
- The engine starts a block only once `s_valid` is high.
- Because the bus cannot pause in the middle of a block, the source must keep `s_valid` high whenever `s_ready` is asserted during a block.
- A stop may leave bytes of the interrupted block unread in the source.

Top module: `sd_write_engine`

## Requirements
- R1: During and directly after reset, `dat_oe`, `s_ready`, `xfer_active`, `busy`, `accepted`, `crc_error`, `program_error` and `busy_timeout` are all low.
- R2: The start bit of a block goes out exactly NWR cycles after the cycle in which `start` is sampled, or after the cycle in which busy ends, provided a byte is offered. It is never sooner.
- R3: A block on the bus has this frame, with `dat_oe` high throughout:
  - one start-bit cycle with all lanes 0;
  - the payload, one byte per two cycles, high nibble first, with lane k carrying bit k of the nibble;
  - sixteen CRC cycles;
  - one end-bit cycle with all lanes 1.
- R4: The CRC is computed separately on each lane over that lane's payload bits. It uses the polynomial x^16+x^12+x^5+1, starts from zero, and is sent most significant bit first.
- R5: Exactly `blk_len` bytes are taken per complete block. The first byte is taken in the start-bit cycle. `s_ready` is only ever high while the engine drives the bus.
- R6: The bus is released from the cycle after the end bit. The token is read on lane 0 in the third to seventh cycles after the end bit, as a start bit, three status bits and an end bit. The outcome is reported in the cycle right after the token end bit.
- R7: A start bit 0 followed by status 010 gives a one-cycle `accepted` pulse.
- R8: Status 101 after a start bit 0, and any other pattern that is neither 010-with-start nor all ones, gives a one-cycle `crc_error` pulse.
- R9: A token window that reads all ones (no start bit, status 111) sets `program_error`.
  - In single-block mode the engine then goes idle.
  - In multiple-block mode it sends no further block and waits for `stop`.
  - `program_error` clears on the next `start`.
- R10: After an accepted or rejected token, `busy` stays high while lane 0 is low, and the engine starts no block in that time. Once lane 0 is high, a multiple-block transfer continues with the next gap and a single-block transfer ends.
- R11: If lane 0 stays low for BUSY_TO consecutive busy cycles, `busy_timeout` is set and the engine returns to idle. `busy_timeout` clears on the next `start`.
- R12: A `stop` sampled while a block is being sent lets exactly one more payload or CRC cycle go out. An end-bit cycle follows, then the bus is released for two cycles. No outcome is reported for that block. The engine then waits for busy to end and goes idle.
- R13: A `stop` sampled during busy makes the engine idle once busy ends. A `stop` sampled while waiting after a programming failure makes it idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bit per lane per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: card response to the write command received |
| multi | input | 1 | Sampled with `start`: 1 selects multiple-block mode |
| stop | input | 1 | Pulse: end bit of the stop command just sent |
| blk_len | input | LEN_W | Block length in bytes (at least 1) |
| s_valid | input | 1 | Payload byte offered |
| s_data | input | 8 | Payload byte |
| s_ready | output | 1 | Payload byte taken this cycle |
| dat_i | input | DAT_W | Sampled data lines |
| dat_o | output | DAT_W | Driven data lines |
| dat_oe | output | 1 | Data line output enable |
| xfer_active | output | 1 | Engine is not idle |
| busy | output | 1 | Waiting for the card to release lane 0 |
| accepted | output | 1 | Pulse: block accepted by the card |
| crc_error | output | 1 | Pulse: card reported a CRC error or a malformed token |
| program_error | output | 1 | Sticky: card reported a programming failure |
| busy_timeout | output | 1 | Sticky: busy lasted too long |

## Verification
The embedded properties watch the following on every cycle:
- the minimum gap before a start bit;
- the all-ones end bit before each release;
- the fixed eight-cycle distance from the end bit to the outcome pulse;
- that accepted and rejected outcomes are exclusive;
- that no bus drive occurs while lane 0 is held low in busy or after a programming failure;
- that a timeout is only raised from a low line in busy.

Only the bench scenarios can show the rest: the bit-exact payload and CRC contents of a frame, which outcome each token pattern produces, the exact busy length, and the clean wind-down after a stop at each phase.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GAP,
    ST_SBIT,
    ST_DATA,
    ST_CRC,
    ST_EBIT,
    ST_TURN,
    ST_TOKEN,
    ST_BUSY,
    ST_HALT
  } sdw_state_e;

  typedef enum logic [1:0] {
    TOK_OK,
    TOK_CRC,
    TOK_PROG
  } sdw_tok_e;

  localparam logic [15:0] SDW_CRC_POLY = 16'h1021;

endpackage

// File: rtl/sdw_crc16_lane.sv
module sdw_crc16_lane
  import sdw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic feed,
  input  logic bit_in,
  input  logic drain,
  output logic msb
);

  logic [15:0] crc;

  // R4: serial CRC16, zero start, shifted out MSB first after the payload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= '0;
    end else if (clr) begin
      crc <= '0;
    end else if (feed) begin
      crc <= {crc[14:0], 1'b0} ^ ((bit_in ^ crc[15]) ? SDW_CRC_POLY : 16'h0000);
    end else if (drain) begin
      crc <= {crc[14:0], 1'b0};
    end
  end

  assign msb = crc[15];

endmodule

// File: rtl/sdw_token_decode.sv
module sdw_token_decode
  import sdw_pkg::*;
(
  input  logic [3:0] tok,
  output sdw_tok_e   res
);

  // tok = {start, s2, s1, s0}; R7 R8 R9
  always_comb begin
    case (tok)
      4'b0010: res = TOK_OK;
      4'b1111: res = TOK_PROG;
      default: res = TOK_CRC;
    endcase
  end

endmodule

// File: rtl/sd_write_engine.sv
module sd_write_engine
  import sdw_pkg::*;
#(
  parameter int DAT_W   = 4,
  parameter int LEN_W   = 10,
  parameter int NWR     = 2,
  parameter int BUSY_TO = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             multi,
  input  logic             stop,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  input  logic [DAT_W-1:0] dat_i,
  output logic [DAT_W-1:0] dat_o,
  output logic             dat_oe,
  output logic             xfer_active,
  output logic             busy,
  output logic             accepted,
  output logic             crc_error,
  output logic             program_error,
  output logic             busy_timeout
);

  localparam int CPB   = 8 / DAT_W;
  localparam int SUB_W = (CPB > 1) ? $clog2(CPB) : 1;
  localparam int GAP_W = $clog2(NWR + 1);
  localparam int TO_W  = (BUSY_TO > 2) ? $clog2(BUSY_TO) : 1;

  sdw_state_e       state;
  logic [GAP_W-1:0] gap_cnt;
  logic [SUB_W-1:0] sub;
  logic [LEN_W-1:0] byte_cnt;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [3:0]       tok;
  logic [TO_W-1:0]  to_cnt;
  logic             closing;
  logic             fin;
  sdw_tok_e         tok_res;

  logic [DAT_W-1:0] nib;
  logic [DAT_W-1:0] crc_msb;
  logic             last_sub;
  logic             last_byte;
  logic             fin_now;

  assign nib       = shreg[7 -: DAT_W];
  assign last_sub  = (sub == SUB_W'(CPB - 1));
  assign last_byte = (byte_cnt == blk_len - LEN_W'(1));
  assign fin_now   = fin | stop;

  genvar k;
  generate
    for (k = 0; k < DAT_W; k++) begin : g_lane
      sdw_crc16_lane u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state == ST_SBIT),
        .feed   (state == ST_DATA),
        .bit_in (nib[k]),
        .drain  (state == ST_CRC),
        .msb    (crc_msb[k])
      );
    end
  endgenerate

  sdw_token_decode u_dec (
    .tok (tok),
    .res (tok_res)
  );

  always_comb begin
    case (state)
      ST_SBIT: dat_o = '0;
      ST_DATA: dat_o = nib;
      ST_CRC:  dat_o = crc_msb;
      default: dat_o = '1;
    endcase
  end

  assign dat_oe      = (state == ST_SBIT) || (state == ST_DATA) ||
                       (state == ST_CRC)  || (state == ST_EBIT);
  assign s_ready     = (state == ST_SBIT) ||
                       ((state == ST_DATA) && last_sub && !last_byte && !closing);
  assign xfer_active = (state != ST_IDLE);
  assign busy        = (state == ST_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      gap_cnt       <= '0;
      sub           <= '0;
      byte_cnt      <= '0;
      bit_cnt       <= '0;
      shreg         <= '0;
      tok           <= '0;
      to_cnt        <= '0;
      closing       <= 1'b0;
      fin           <= 1'b0;
      accepted      <= 1'b0;
      crc_error     <= 1'b0;
      program_error <= 1'b0;
      busy_timeout  <= 1'b0;
    end else begin
      accepted  <= 1'b0;
      crc_error <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state         <= ST_GAP;
            gap_cnt       <= GAP_W'(NWR - 1);
            fin           <= !multi;
            closing       <= 1'b0;
            program_error <= 1'b0;
            busy_timeout  <= 1'b0;
          end
        end
        ST_GAP: begin
          if (stop)                 state   <= ST_IDLE;
          else if (gap_cnt != '0)   gap_cnt <= gap_cnt - GAP_W'(1);
          else if (s_valid)         state   <= ST_SBIT;
        end
        ST_SBIT: begin
          shreg    <= s_data;
          sub      <= '0;
          byte_cnt <= '0;
          state    <= ST_DATA;
          if (stop) begin closing <= 1'b1; fin <= 1'b1; end
        end
        ST_DATA: begin
          if (closing) begin
            state <= ST_EBIT;
          end else if (last_sub) begin
            if (last_byte) begin
              state   <= ST_CRC;
              bit_cnt <= 4'd15;
            end else begin
              shreg    <= s_data;
              sub      <= '0;
              byte_cnt <= byte_cnt + LEN_W'(1);
            end
          end else begin
            shreg <= shreg << DAT_W;
            sub   <= sub + SUB_W'(1);
          end
          if (stop) begin closing <= 1'b1; fin <= 1'b1; end
        end
        ST_CRC: begin
          if (closing || bit_cnt == 4'd0) state   <= ST_EBIT;
          else                            bit_cnt <= bit_cnt - 4'd1;
          if (stop) begin closing <= 1'b1; fin <= 1'b1; end
        end
        ST_EBIT: begin
          state   <= ST_TURN;
          bit_cnt <= 4'd1;
          if (stop) begin closing <= 1'b1; fin <= 1'b1; end
        end
        ST_TURN: begin
          if (bit_cnt == 4'd0) begin
            to_cnt <= '0;
            if (closing || stop) begin
              state <= ST_BUSY;
              fin   <= 1'b1;
            end else begin
              state   <= ST_TOKEN;
              bit_cnt <= 4'd4;
            end
          end else begin
            bit_cnt <= bit_cnt - 4'd1;
            if (stop) begin closing <= 1'b1; fin <= 1'b1; end
          end
        end
        ST_TOKEN: begin
          to_cnt <= '0;
          if (stop) begin
            // R12: interrupted token, block not counted
            state <= ST_BUSY;
            fin   <= 1'b1;
          end else if (bit_cnt != 4'd0) begin
            tok     <= {tok[2:0], dat_i[0]};
            bit_cnt <= bit_cnt - 4'd1;
          end else begin
            case (tok_res)
              TOK_OK: begin
                accepted <= 1'b1;
                state    <= ST_BUSY;
              end
              TOK_PROG: begin
                program_error <= 1'b1;
                state         <= fin ? ST_IDLE : ST_HALT;
              end
              default: begin
                crc_error <= 1'b1;
                state     <= ST_BUSY;
              end
            endcase
          end
        end
        ST_BUSY: begin
          if (stop) fin <= 1'b1;
          if (dat_i[0]) begin
            state   <= fin_now ? ST_IDLE : ST_GAP;
            gap_cnt <= GAP_W'(NWR - 1);
          end else if (to_cnt == TO_W'(BUSY_TO - 1)) begin
            busy_timeout <= 1'b1;
            state        <= ST_IDLE;
          end else begin
            to_cnt <= to_cnt + TO_W'(1);
          end
        end
        ST_HALT: begin
          if (stop) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Quiet-cycle counter used only by the gap check below
  logic [GAP_W-1:0] quiet_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  quiet_cnt <= '0;
    else if ((start && state == ST_IDLE) || busy) quiet_cnt <= '0;
    else if (quiet_cnt < GAP_W'(NWR))            quiet_cnt <= quiet_cnt + GAP_W'(1);
  end

  assert_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_oe) |-> (quiet_cnt >= GAP_W'(NWR)));

  assert_end_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_oe) |-> ($past(dat_o) == {DAT_W{1'b1}}));

  assert_ready_when_driving_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> dat_oe);

  assert_token_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted || crc_error) |-> ($past(dat_oe, 8) && !$past(dat_oe, 7)));

  assert_outcome_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accepted, crc_error}));

  assert_no_block_after_prog_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    program_error |-> !dat_oe);

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dat_i[0]) |=> !dat_oe);

  assert_timeout_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_timeout) |-> ($past(busy) && !$past(dat_i[0])));

endmodule

// File: tb/sd_write_engine_test.sv
module sd_write_engine_test;

  localparam int DW   = 4;
  localparam int LW   = 10;
  localparam int GAP  = 2;
  localparam int TOUT = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          multi = 1'b0;
  logic          stop = 1'b0;
  logic [LW-1:0] blk_len = '0;
  logic          s_valid = 1'b0;
  logic [7:0]    s_data = '0;
  logic          s_ready;
  logic [DW-1:0] dat_i = '1;
  logic [DW-1:0] dat_o;
  logic          dat_oe;
  logic          xfer_active, busy, accepted, crc_error, program_error, busy_timeout;

  sd_write_engine #(.DAT_W(DW), .LEN_W(LW), .NWR(GAP), .BUSY_TO(TOUT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .multi(multi), .stop(stop),
    .blk_len(blk_len), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe), .xfer_active(xfer_active),
    .busy(busy), .accepted(accepted), .crc_error(crc_error),
    .program_error(program_error), .busy_timeout(busy_timeout)
  );

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  int idx = 0, pos = 0, nb = 0, n_acc = 0, n_crc = 0;
  bit adv = 0;
  logic [DW-1:0] bitlog [512];
  logic [7:0]    bytelog [256];

  // Vector table: length, token {start,s2,s1,s0}, low busy cycles, expected outcomes
  localparam int          NV = 6;
  localparam int          V_LEN  [NV] = '{4, 1, 8, 3, 5, 2};
  localparam logic [3:0]  V_TOK  [NV] = '{4'b0010, 4'b0010, 4'b0101, 4'b1111, 4'b0110, 4'b0010};
  localparam int          V_BCYC [NV] = '{3, 0, 2, 0, 1, 25};
  localparam int          V_BEXP [NV] = '{4, 1, 3, 0, 2, 20};
  localparam logic [2:0]  V_OUT  [NV] = '{3'b100, 3'b100, 3'b010, 3'b001, 3'b010, 3'b100};

  function automatic logic [7:0] pat(int i);
    return 8'((i * 29 + 7) & 255);
  endfunction

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    logic fb;
    fb = b ^ c[15];
    c = {c[14:0], 1'b0};
    if (fb) c = c ^ 16'h1021;
    return c;
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (adv) begin idx++; s_data = pat(idx); adv = 0; end
    if (s_valid && s_ready) begin bytelog[nb] = s_data; nb++; adv = 1; end
    if (dat_oe) begin bitlog[pos] = dat_o; pos++; end
    if (accepted) n_acc++;
    if (crc_error) n_crc++;
  endtask

  task automatic check_frame(int len);
    int bad_d = 0, bad_c = 0;
    chk("R5 bytes taken", nb, len);
    chk("R3 frame length", pos, 2 * len + 18);
    chk("R3 start bit", int'(bitlog[0]), 0);
    for (int i = 0; i < len; i++) begin
      if (bitlog[1 + 2 * i] != bytelog[i][7:4]) bad_d++;
      if (bitlog[2 + 2 * i] != bytelog[i][3:0]) bad_d++;
    end
    chk("R3 payload nibbles", bad_d, 0);
    for (int l = 0; l < DW; l++) begin
      logic [15:0] c = '0;
      for (int i = 0; i < 2 * len; i++) c = crc_step(c, bitlog[1 + i][l]);
      for (int j = 0; j < 16; j++)
        if (bitlog[1 + 2 * len + j][l] != c[15 - j]) bad_c++;
    end
    chk("R4 crc bits", bad_c, 0);
    chk("R3 end bit", int'(bitlog[2 * len + 17]), 15);
  endtask

  // Start already issued or busy just released; runs one block to busy end
  task automatic run_block(int len, logic [3:0] tk, int bcyc, int bexp, logic [2:0] outc, bit stop_busy);
    int g = 0, bc = 0;
    pos = 0; nb = 0; n_acc = 0; n_crc = 0;
    blk_len = LW'(len);
    while (!dat_oe) begin g++; tick(); end
    chk("R2 gap cycles", g, GAP);
    while (dat_oe) tick();
    check_frame(len);
    tick();
    tick(); dat_i[0] = tk[3];
    tick(); dat_i[0] = tk[2];
    tick(); dat_i[0] = tk[1];
    tick(); dat_i[0] = tk[0];
    tick(); dat_i[0] = 1'b1;
    tick();
    chk("R6 R7 accepted at outcome cycle", int'(accepted), int'(outc[2]));
    chk("R6 R8 crc_error at outcome cycle", int'(crc_error), int'(outc[1]));
    chk("R9 program_error", int'(program_error), int'(outc[0]));
    for (int i = 0; i < bcyc; i++) begin
      dat_i[0] = 1'b0;
      if (stop_busy && i == 0) stop = 1'b1;
      if (busy) bc++;
      tick();
      stop = 1'b0;
    end
    dat_i[0] = 1'b1;
    if (busy) bc++;
    tick();
    chk("R10 R11 busy cycles", bc, bexp);
  endtask

  task automatic do_start(bit m);
    multi = m; start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    s_data = pat(0);
    repeat (3) @(negedge clk);
    chk("R1 dat_oe in reset", int'(dat_oe), 0);
    chk("R1 active in reset", int'(xfer_active), 0);
    rst_n = 1'b1;
    s_valid = 1'b1;
    tick();
    chk("R1 s_ready after reset", int'(s_ready), 0);
    chk("R1 outputs after reset",
        int'({busy, accepted, crc_error, program_error, busy_timeout}), 0);

    // Table-driven single-block writes
    for (int v = 0; v < NV; v++) begin
      do_start(1'b0);
      if (v == 4) chk("R9 program_error cleared by start", int'(program_error), 0);
      run_block(V_LEN[v], V_TOK[v], V_BCYC[v], V_BEXP[v], V_OUT[v], 1'b0);
      chk("R10 single block ends idle", int'(xfer_active), 0);
      if (v == 5) chk("R11 busy_timeout set", int'(busy_timeout), 1);
      repeat (2) tick();
    end
    do_start(1'b0);
    chk("R11 busy_timeout cleared by start", int'(busy_timeout), 0);
    run_block(2, 4'b0010, 0, 1, 3'b100, 1'b0);
    repeat (2) tick();

    // Multiple blocks, then a programming failure, then stop
    do_start(1'b1);
    run_block(3, 4'b0010, 4, 5, 3'b100, 1'b0);
    chk("R10 multi continues after busy", int'(xfer_active), 1);
    run_block(2, 4'b1111, 0, 0, 3'b001, 1'b0);
    begin
      int drv = 0;
      for (int i = 0; i < 10; i++) begin
        if (dat_oe) drv++;
        tick();
      end
      chk("R9 no block after programming failure", drv, 0);
      chk("R9 waits for stop", int'(xfer_active), 1);
    end
    stop = 1'b1; tick(); stop = 1'b0;
    chk("R13 stop while halted ends transfer", int'(xfer_active), 0);
    repeat (2) tick();

    // Stop during busy
    do_start(1'b1);
    run_block(2, 4'b0010, 3, 4, 3'b100, 1'b1);
    chk("R13 stop in busy ends transfer", int'(xfer_active), 0);
    repeat (2) tick();

    // Stop while a block is on the bus
    do_start(1'b1);
    blk_len = LW'(6);
    pos = 0; nb = 0; n_acc = 0; n_crc = 0;
    while (!dat_oe) tick();
    repeat (3) tick();
    stop = 1'b1; tick(); stop = 1'b0;
    tick();
    tick();
    chk("R12 cycles driven after stop", pos, 6);
    chk("R12 extra payload cycle", int'(bitlog[4]), int'(bytelog[1][3:0]));
    chk("R12 end bit after stop", int'(bitlog[5]), 15);
    chk("R12 bus released", int'(dat_oe), 0);
    tick(); tick();
    chk("R12 busy after stop", int'(busy), 1);
    dat_i[0] = 1'b0; tick(); tick();
    dat_i[0] = 1'b1; tick();
    chk("R12 idle after busy", int'(xfer_active), 0);
    chk("R12 no outcome reported", n_acc + n_crc, 0);
    chk("R5 bytes taken before stop", nb, 2);

    repeat (3) tick();
    summary();
  end

endmodule